// File: doc/BRIEF.md
# Eight-bit Addressed GPIO Expander Core

This block holds the registers and pad-side logic of an eight-bit I/O expander that sits behind a two-wire serial target. The serial front end, which is not part of this block, has already handled bit timing, start and stop conditions and address matching. It passes on three byte-level events: the start of a write transaction, a received byte with its data, and a read request that expects one byte back.

The first byte received after a write start is a command byte. Its low two bits set a register pointer. Any further bytes in the same transaction write the register that the pointer selects, and the pointer does not advance. A read returns the register at the current pointer one cycle after the request. Four registers are visible: the sensed pin levels, the output latch, a per-bit polarity inversion and a per-bit direction. A direction bit of 1 makes its pin a high-impedance input. A direction bit of 0 makes its pin an output driven from the output latch. Pin levels pass through a two-flop synchronizer and a capture register before they can be read.

Top module: `gpio_expander_core`

## Requirements
- R1: After reset the output latch is 0x00, the polarity register is 0xF0, the direction register is 0xFF, the pointer selects the input register (code 0), and every pin_oe_o bit is 0.
- R2: The first byte after wr_start_i is a command. Only its bits [1:0] set the pointer: 0 selects input, 1 output, 2 polarity and 3 direction. Bits [7:2] are ignored.
- R3: Every byte after the command writes the register at the pointer. The pointer does not increment, and it keeps its value across transactions and reads until the next command byte arrives.
- R4: A data byte written while the pointer selects the input register changes no register and no pin output.
- R5: pin_oe_o[i] is the inverse of direction bit i, and pin_o always presents the output latch.
- R6: A read of the output register returns the latch value, even when the pins are inputs that carry other levels.
- R7: The input register shows the level on every pin, whatever the pin's direction. A pin change becomes readable by a read request accepted on the fourth rising edge after the change.
- R8: A read of the input register returns each pin level XOR (polarity bit AND direction bit). Polarity has no effect on output pins.
- R9: rd_valid_o is high for exactly one cycle, on the cycle after each accepted rd_req_i. rd_data_o holds the register that the pointer selected at acceptance, and it keeps that value until the next request.
- R10: rst_ni is asynchronous and active low. While it is low, pin_oe_o and pin_o stay 0 and bytes are ignored. The defaults of R1 are in place when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on or external) |
| wr_start_i | input | 1 | Start of a write transaction; the next byte is a command |
| wr_byte_i | input | 1 | A received byte is valid this cycle |
| wr_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Request for one read byte |
| rd_data_o | output | 8 | Returned read byte |
| rd_valid_o | output | 1 | rd_data_o was refreshed this cycle |
| pin_i | input | 8 | Sensed pad levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad output enables, 1 = drive |

## Verification
The assertions assume that the serial front end never raises wr_start_i and wr_byte_i in the same cycle, because a transaction start and a received byte cannot coincide. One assertion states this assumption directly. The bench drives each event in its own cycle, with inputs changed on the falling edge, and models the pads as outputs wherever pin_oe_o is set and as a bench-driven level elsewhere. The pin-latency property assumes pin_i is sampled only at rising edges, and the bench changes pin levels only on falling edges to match.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_IN  = 2'd0,
    SEL_OUT = 2'd1,
    SEL_POL = 2'd2,
    SEL_DIR = 2'd3
  } regsel_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpx_port.sv
module gpx_port #(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] dir_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] in_view_o
);
  localparam int unsigned LAT = SYNC_STAGES + 1;
  localparam int unsigned CW  = $clog2(LAT + 1);

  logic [W-1:0] sync_q;
  logic [W-1:0] in_q;

  gpx_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (sync_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_q <= '0;
    else         in_q <= sync_q;
  end

  // inversion applies only to pins configured as inputs
  assign in_view_o = in_q ^ (pol_i & dir_i);

  for (genvar b = 0; b < W; b++) begin : g_pad
    assign pin_o[b]    = out_i[b];
    assign pin_oe_o[b] = ~dir_i[b];
  end

  logic [CW-1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  warm_q <= '0;
    else if (warm_q != CW'(LAT))  warm_q <= warm_q + 1'b1;
  end

  a_r7_input_latency: assert property (@(posedge clk_i)
    disable iff (!rst_ni || warm_q != CW'(LAT))
    in_q == $past(pin_i, 3));
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter logic [W-1:0] OUT_RST = '0,
  parameter logic [W-1:0] POL_RST = '0,
  parameter logic [W-1:0] DIR_RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_start_i,
  input  logic         wr_byte_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_req_i,
  input  logic [W-1:0] in_view_i,
  output logic [W-1:0] rd_data_o,
  output logic         rd_valid_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] dir_o
);
  logic         cmd_pend_q;
  regsel_e      ptr_q;
  logic [W-1:0] out_q, pol_q, dir_q;
  logic [W-1:0] rd_data_q, rd_mux;
  logic         rd_valid_q;
  logic         data_wr;

  assign data_wr = wr_byte_i && !cmd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_pend_q <= 1'b1;
      ptr_q      <= SEL_IN;
      out_q      <= OUT_RST;
      pol_q      <= POL_RST;
      dir_q      <= DIR_RST;
    end else if (wr_start_i) begin
      cmd_pend_q <= 1'b1;
    end else if (wr_byte_i) begin
      if (cmd_pend_q) begin
        ptr_q      <= regsel_e'(wr_data_i[SEL_W-1:0]);
        cmd_pend_q <= 1'b0;
      end else begin
        unique case (ptr_q)
          SEL_OUT: out_q <= wr_data_i;
          SEL_POL: pol_q <= wr_data_i;
          SEL_DIR: dir_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (ptr_q)
      SEL_IN:  rd_mux = in_view_i;
      SEL_OUT: rd_mux = out_q;
      SEL_POL: rd_mux = pol_q;
      default: rd_mux = dir_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req_i;
      if (rd_req_i) rd_data_q <= rd_mux;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  assign out_o      = out_q;
  assign pol_o      = pol_q;
  assign dir_o      = dir_q;

  // input assumption: front end never marks a start and a byte together
  a_r2_no_start_with_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_start_i && wr_byte_i));

  a_r2_ptr_only_on_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_byte_i && cmd_pend_q) |=> $stable(ptr_q));

  a_r3_out_only_when_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_wr && ptr_q == SEL_OUT) |=> $stable(out_q));

  a_r3_dir_only_when_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_wr && ptr_q == SEL_DIR) |=> $stable(dir_q));

  a_r4_input_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && ptr_q == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

  a_r9_valid_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rd_valid_o);

  a_r9_no_valid_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rd_valid_o);

  a_r9_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(rd_data_o));
endmodule

// File: rtl/gpio_expander_core.sv
module gpio_expander_core #(
  parameter int unsigned  W           = 8,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [W-1:0] OUT_RST     = 8'h00,
  parameter logic [W-1:0] POL_RST     = 8'hF0,
  parameter logic [W-1:0] DIR_RST     = 8'hFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_start_i,
  input  logic         wr_byte_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_req_i,
  output logic [W-1:0] rd_data_o,
  output logic         rd_valid_o,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  logic [W-1:0] out_w, pol_w, dir_w, in_view_w;

  gpx_regfile #(
    .W(W), .OUT_RST(OUT_RST), .POL_RST(POL_RST), .DIR_RST(DIR_RST)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_start_i (wr_start_i),
    .wr_byte_i  (wr_byte_i),
    .wr_data_i  (wr_data_i),
    .rd_req_i   (rd_req_i),
    .in_view_i  (in_view_w),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o),
    .out_o      (out_w),
    .pol_o      (pol_w),
    .dir_o      (dir_w)
  );

  gpx_port #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin_i),
    .out_i     (out_w),
    .pol_i     (pol_w),
    .dir_i     (dir_w),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .in_view_o (in_view_w)
  );
endmodule

// File: tb/sim_gpio_expander_core.sv
module sim_gpio_expander_core;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_start = 1'b0, wr_byte = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, pin_o, pin_oe, pin_in, ext;
  logic       rd_valid;
  int         checks = 0, errors = 0;
  logic [7:0] mo, mp, md, v;

  always #4 clk = ~clk;

  assign pin_in = (pin_oe & pin_o) | (~pin_oe & ext);

  gpio_expander_core u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_start_i(wr_start), .wr_byte_i(wr_byte),
    .wr_data_i(wr_data), .rd_req_i(rd_req), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .pin_i(pin_in), .pin_o(pin_o), .pin_oe_o(pin_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    wr_start = 1; tick; wr_start = 0;
    wr_byte = 1; wr_data = c; tick;
    wr_data = d; tick; wr_byte = 0;
  endtask

  task automatic rd(output logic [7:0] val);
    rd_req = 1; tick; rd_req = 0;
    chk("R9 valid", {7'd0, rd_valid}, 8'd1);
    val = rd_data;
  endtask

  task automatic rd_reg(input logic [7:0] c, output logic [7:0] val);
    wr_start = 1; tick; wr_start = 0;
    wr_byte = 1; wr_data = c; tick; wr_byte = 0;
    rd(val);
  endtask

  function automatic logic [7:0] in_exp(input logic [7:0] e);
    logic [7:0] pin = (~md & mo) | (md & e);
    return pin ^ (mp & md);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ext = 8'h5A;
    repeat (3) tick;
    chk("R10 oe in reset", pin_oe, 8'h00);
    rst_ni = 1; mo = 8'h00; mp = 8'hF0; md = 8'hFF;
    repeat (4) tick;
    // R1 defaults, pointer on input register
    chk("R1 oe", pin_oe, 8'h00);
    chk("R1 pin_o", pin_o, 8'h00);
    rd(v); chk("R1 ptr=input", v, 8'h5A ^ 8'hF0);
    rd_reg(8'd1, v); chk("R1 out", v, 8'h00);
    rd_reg(8'd2, v); chk("R1 pol", v, 8'hF0);
    rd_reg(8'd3, v); chk("R1 dir", v, 8'hFF);
    tick; chk("R9 single valid", {7'd0, rd_valid}, 8'd0);

    // R2 upper command bits ignored
    wr(8'hFD, 8'h3C); mo = 8'h3C;
    chk("R2 cmd FD->out", pin_o, 8'h3C);
    wr(8'h06, 8'h0F); mp = 8'h0F;
    rd_reg(8'h02, v); chk("R2 cmd 06->pol", v, 8'h0F);

    // R3 multiple bytes to same register, pointer retained
    wr_start = 1; tick; wr_start = 0;
    wr_byte = 1; wr_data = 8'd3; tick;
    wr_data = 8'h0F; tick; wr_data = 8'hF0; tick; wr_byte = 0;
    md = 8'hF0;
    chk("R3 last byte wins", pin_oe, 8'h0F);
    chk("R3 out untouched", pin_o, 8'h3C);
    wr_start = 1; tick; wr_start = 0;
    rd(v); chk("R3 ptr kept over start", v, 8'hF0);
    rd(v); chk("R3 ptr kept over read", v, 8'hF0);

    // R4 write to input register ignored
    wr(8'd0, 8'h77);
    chk("R4 pin_o", pin_o, mo);
    chk("R4 oe", pin_oe, ~md);
    rd_reg(8'd1, v); chk("R4 out", v, mo);
    rd_reg(8'd2, v); chk("R4 pol", v, mp);
    rd_reg(8'd3, v); chk("R4 dir", v, md);

    // R7 latency: all inputs, no inversion
    wr(8'd3, 8'hFF); md = 8'hFF;
    wr(8'd2, 8'h00); mp = 8'h00;
    wr_start = 1; tick; wr_start = 0;
    wr_byte = 1; wr_data = 8'd0; tick; wr_byte = 0;
    ext = 8'h11; repeat (5) tick;
    ext = 8'hEE; rd_req = 1;
    for (int k = 1; k <= 4; k++) begin
      tick;
      chk("R7 latency", rd_data, (k < 4) ? 8'h11 : 8'hEE);
      chk("R9 back-to-back valid", {7'd0, rd_valid}, 8'd1);
    end
    rd_req = 0;

    // R5/R6/R7/R8 sweep
    for (int i = 0; i < 64; i++) begin
      logic [7:0] o, p, d, e;
      o = 8'(i * 53 + 7); p = 8'(i * 91 + 3); d = 8'(i * 37 + 1); e = 8'(i * 29 + 5);
      ext = e;
      wr(8'd1, o); wr(8'd2, p); wr(8'd3, d);
      mo = o; mp = p; md = d;
      repeat (4) tick;
      chk("R5 oe", pin_oe, ~d);
      chk("R5 pin_o", pin_o, o);
      rd_reg(8'd1, v); chk("R6 out latch", v, o);
      rd_reg(8'd2, v); chk("R8 pol readback", v, p);
      rd_reg(8'd3, v); chk("R3 dir readback", v, d);
      rd_reg(8'd0, v); chk("R8 input view", v, in_exp(e));
    end

    // R10 asynchronous reset, bytes ignored while held
    wr(8'd3, 8'h00); wr(8'd1, 8'hAA);
    #1 rst_ni = 0; #1;
    chk("R10 async oe", pin_oe, 8'h00);
    chk("R10 async pin_o", pin_o, 8'h00);
    tick;
    wr(8'd3, 8'h00); wr(8'd1, 8'h55);
    chk("R10 held oe", pin_oe, 8'h00);
    chk("R10 held pin_o", pin_o, 8'h00);
    rst_ni = 1; mo = 8'h00; mp = 8'hF0; md = 8'hFF; ext = 8'h3C;
    repeat (4) tick;
    rd(v); chk("R10 ptr default", v, 8'h3C ^ 8'hF0);
    rd_reg(8'd1, v); chk("R10 out default", v, 8'h00);
    rd_reg(8'd2, v); chk("R10 pol default", v, 8'hF0);
    rd_reg(8'd3, v); chk("R10 dir default", v, 8'hFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule